// File: doc/BRIEF.md
# ECC Sub-Word Store Merge with Silent-Store Squash

This block is the store path of a data cache whose 64-bit words are protected by a single-error-correct, double-error-detect code. A store narrower than the protected word cannot simply overwrite its bytes, because the check bits cover the whole word. The block therefore reads the old word and its check bits, corrects and checks that word, inserts the new bytes, computes fresh check bits and writes the result back.

That read-modify-write already brings the old value next to the new one. The block compares the merged word with the corrected old word in the same cycle as the merge and the check-bit generation. When the store would leave the word unchanged and the read found no error, the write-back is dropped. A word with a single-bit error is always rewritten, so the repaired value lands in the array. A word with a double-bit error is left alone and the store is abandoned. Full 64-bit stores need no old data and are written directly.

The word array sits outside the block as a simple synchronous memory with one-cycle read latency. The caller sees a valid/ready request and a set of one-cycle status pulses.

Top module: `ecc_store_merge`

## Requirements
- R1: For a sub-word store, the memory read is issued at the request address in the cycle the request is accepted. Any write-back goes to the same address in the next cycle, and `st_done` pulses in the cycle after that.
- R2: The `req_size` encoding is 0 for byte, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. The new bytes come from the low bits of `req_data`. They land at byte lane `req_off` rounded down to a multiple of the access size, where lane b is bits 8b+7..8b. All other lanes keep the corrected old value.
- R3: The written check bits follow one fixed layout. Data bit i sits at the (i+1)-th code position, counting from 1, that is not a power of two. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all data bits and check bits 0..6.
- R4: A sub-word store whose merged word equals the corrected old word, on a read with no error, performs no write and raises `st_squash` with `st_done`.
- R5: A single-bit error in the data or in any check bit is corrected before the merge and the comparison, and the word is always written back, even if the store is silent. `st_corr` pulses with `st_done`.
- R6: A double-bit error aborts the store with no write and raises `st_uncorr` for one cycle with `st_done`.
- R7: A 64-bit store issues no read. It writes data and check bits in its accept cycle, never squashes, and pulses `st_done` in the next cycle.
- R8: In the cycle after a sub-word read, `req_ready` is low and no further read is issued.
- R9: The status outputs are one-cycle pulses that appear only together with `st_done`, and at most one of `st_squash`, `st_corr` and `st_uncorr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the store |
| req_off | input | 3 | Byte offset within the 64-bit word |
| req_size | input | 2 | Access size code (see R2) |
| req_data | input | 64 | Store data, right-aligned |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address for read or write |
| mem_wdata | output | 64 | Word written to memory |
| mem_wchk | output | 8 | Check bits written to memory |
| mem_rdata | input | 64 | Word read from memory, one cycle after the read strobe |
| mem_rchk | input | 8 | Check bits read from memory, one cycle after the read strobe |
| st_done | output | 1 | A store finished |
| st_squash | output | 1 | The finished store was silent and its write was dropped |
| st_corr | output | 1 | A single-bit error was corrected and scrubbed |
| st_uncorr | output | 1 | A double-bit error aborted the store |

## Verification
The in-line assertions watch, on every cycle, the ordering of the memory strobes:
- no read and write together;
- a write back to the read address;
- the busy cycle after a read;
- the one-hot status pulses aligned with completion.

They also check that a squash or an abort was never preceded by a write, and that a correction always was.

Only the bench scenarios can show that the merged bytes and the check bits hold the right values. The same holds for silence being judged against the corrected word rather than the raw one, and for the scrubbed word being clean on the next silent store. For this the bench injects single and double faults into its memory model and predicts every write independently.

// File: rtl/ecc_sm_pkg.sv
package ecc_sm_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned LANES     = WORD_W / 8;
    localparam int unsigned OFF_W     = $clog2(LANES);
    localparam int unsigned HAM_W     = 7;
    localparam int unsigned CHK_W     = HAM_W + 1;
    localparam int unsigned POS_LIMIT = 1 << HAM_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_CHECK = 1'b1
    } phase_e;

    // Code position of a data bit: the (idx+1)-th position that is not a power of two.
    function automatic int unsigned code_pos(input int unsigned idx);
        int unsigned found;
        int unsigned seen;
        found = 0;
        seen  = 0;
        for (int unsigned k = 3; k < POS_LIMIT; k++) begin
            if ((k & (k - 1)) != 0) begin
                if (seen == idx) found = k;
                seen++;
            end
        end
        return found;
    endfunction

    // Data bits covered by Hamming check bit j.
    function automatic logic [WORD_W-1:0] cover_mask(input int unsigned j);
        logic [WORD_W-1:0] m;
        int unsigned       p;
        m = '0;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            p    = code_pos(i);
            m[i] = p[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_sm_encode.sv
module ecc_sm_encode
    import ecc_sm_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [HAM_W-1:0] ham;

    for (genvar j = 0; j < HAM_W; j++) begin : g_ham
        localparam logic [WORD_W-1:0] COVER = cover_mask(j);
        assign ham[j] = ^(data_i & COVER);
    end

    // Top bit is the overall parity across data and Hamming bits.
    assign chk_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/ecc_sm_decode.sv
module ecc_sm_decode
    import ecc_sm_pkg::*;
(
    input  logic [WORD_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  raw_chk,
    output logic [WORD_W-1:0] fixed_data,
    output logic              err_single,
    output logic              err_double
);

    logic [CHK_W-1:0]  recomputed;
    logic [HAM_W-1:0]  syndrome;
    logic              overall;
    logic [WORD_W-1:0] flip;
    logic              data_hit;
    logic              syn_pow2;

    ecc_sm_encode u_regen (
        .data_i (raw_data),
        .chk_o  (recomputed)
    );

    assign syndrome = recomputed[HAM_W-1:0] ^ raw_chk[HAM_W-1:0];
    // Parity of the received code word, rebuilt from the regenerated bits.
    assign overall  = recomputed[HAM_W] ^ raw_chk[HAM_W] ^ (^syndrome);

    for (genvar i = 0; i < WORD_W; i++) begin : g_flip
        localparam int unsigned CP = code_pos(i);
        assign flip[i] = (syndrome == HAM_W'(CP));
    end

    assign data_hit   = |flip;
    assign syn_pow2   = (syndrome & (syndrome - 1'b1)) == '0;
    assign err_single = overall && (data_hit || syn_pow2);
    assign err_double = (!overall && (syndrome != '0)) ||
                        (overall && !data_hit && !syn_pow2);
    assign fixed_data = overall ? (raw_data ^ flip) : raw_data;

endmodule

// File: rtl/ecc_sm_merge.sv
module ecc_sm_merge
    import ecc_sm_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_bits,
    input  logic [OFF_W-1:0]  lane_off,
    input  st_size_e          size_i,
    output logic [WORD_W-1:0] merged_o
);

    logic [LANES-1:0]  lane_en;
    logic [OFF_W-1:0]  base;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                base    = lane_off;
                lane_en = LANES'(1) << base;
            end
            SZ_HALF: begin
                base    = {lane_off[OFF_W-1:1], 1'b0};
                lane_en = LANES'(2'b11) << base;
            end
            SZ_WORD: begin
                base    = {lane_off[OFF_W-1], 2'b00};
                lane_en = LANES'(4'hF) << base;
            end
            default: begin
                base    = '0;
                lane_en = '1;
            end
        endcase
        shifted = new_bits << {base, 3'b000};
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged_o[8*b +: 8] = lane_en[b] ? shifted[8*b +: 8] : old_word[8*b +: 8];
    end

endmodule

// File: rtl/ecc_store_merge.sv
module ecc_store_merge
    import ecc_sm_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_off,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_data,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic [7:0]        mem_wchk,
    input  logic [63:0]       mem_rdata,
    input  logic [7:0]        mem_rchk,
    output logic              st_done,
    output logic              st_squash,
    output logic              st_corr,
    output logic              st_uncorr
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  off;
        st_size_e          size;
        logic [WORD_W-1:0] data;
        logic              done;
        logic              squash;
        logic              corr;
        logic              uncorr;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [WORD_W-1:0] fixed_word;
    logic              err_single, err_double;
    logic [WORD_W-1:0] merged_word;
    logic [WORD_W-1:0] enc_src;
    logic [CHK_W-1:0]  enc_chk;
    logic              unchanged;

    ecc_sm_decode u_dec (
        .raw_data   (mem_rdata),
        .raw_chk    (mem_rchk),
        .fixed_data (fixed_word),
        .err_single (err_single),
        .err_double (err_double)
    );

    ecc_sm_merge u_mrg (
        .old_word (fixed_word),
        .new_bits (cur_q.data),
        .lane_off (cur_q.off),
        .size_i   (cur_q.size),
        .merged_o (merged_word)
    );

    assign enc_src = (cur_q.phase == PH_CHECK) ? merged_word : req_data;

    ecc_sm_encode u_enc (
        .data_i (enc_src),
        .chk_o  (enc_chk)
    );

    // Silence test runs beside encode, on the corrected old word.
    assign unchanged = (merged_word == fixed_word);

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.done   = 1'b0;
        nxt_d.squash = 1'b0;
        nxt_d.corr   = 1'b0;
        nxt_d.uncorr = 1'b0;
        req_ready    = (cur_q.phase == PH_IDLE);
        mem_rd_en    = 1'b0;
        mem_wr_en    = 1'b0;
        mem_addr     = cur_q.addr;
        mem_wdata    = enc_src;
        mem_wchk     = enc_chk;
        unique case (cur_q.phase)
            PH_IDLE: begin
                mem_addr = req_addr;
                if (req_valid) begin
                    if (st_size_e'(req_size) == SZ_DWORD) begin
                        mem_wr_en  = 1'b1;
                        nxt_d.done = 1'b1;
                    end else begin
                        mem_rd_en   = 1'b1;
                        nxt_d.phase = PH_CHECK;
                        nxt_d.addr  = req_addr;
                        nxt_d.off   = req_off;
                        nxt_d.size  = st_size_e'(req_size);
                        nxt_d.data  = req_data;
                    end
                end
            end
            default: begin
                nxt_d.phase = PH_IDLE;
                nxt_d.done  = 1'b1;
                if (err_double) begin
                    nxt_d.uncorr = 1'b1;
                end else if (err_single) begin
                    mem_wr_en  = 1'b1;
                    nxt_d.corr = 1'b1;
                end else if (unchanged) begin
                    nxt_d.squash = 1'b1;
                end else begin
                    mem_wr_en = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign st_done   = cur_q.done;
    assign st_squash = cur_q.squash;
    assign st_corr   = cur_q.corr;
    assign st_uncorr = cur_q.uncorr;

    // R1: one memory operation per cycle; write-back reuses the read address
    p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    p_wr_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr)));
    p_rd_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 st_done);
    // R8: busy cycle follows each read
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!req_ready && !mem_rd_en));
    // R9: status pulses
    p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_squash, st_corr, st_uncorr}));
    p_flags_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_squash || st_corr || st_uncorr) |-> st_done);
    // R4, R5, R6: write decision seen from the status side
    p_squash_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_squash |-> !$past(mem_wr_en));
    p_corr_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_corr |-> $past(mem_wr_en));
    p_uncorr_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_uncorr |-> !$past(mem_wr_en));
    // R7: a write with no read before it is a full store, done next cycle
    p_full_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !$past(mem_rd_en)) |=> (st_done && !st_squash));

endmodule

// File: tb/ecc_store_merge_test.sv
`timescale 1ns/1ps
module ecc_store_merge_test;
    import ecc_sm_pkg::*;

    localparam int unsigned AW    = 5;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_off = '0;
    logic [1:0]    req_size = '0;
    logic [63:0]   req_data = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [7:0]    mem_wchk;
    logic [63:0]   mem_rdata = '0;
    logic [7:0]    mem_rchk = '0;
    logic          st_done, st_squash, st_corr, st_uncorr;

    always #2.5 clk = ~clk;

    ecc_store_merge #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_off(req_off), .req_size(req_size), .req_data(req_data),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
        .mem_rdata(mem_rdata), .mem_rchk(mem_rchk),
        .st_done(st_done), .st_squash(st_squash), .st_corr(st_corr), .st_uncorr(st_uncorr)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference code per R3, built by accumulating positions.
    function automatic int unsigned tb_pos(input int unsigned i);
        int unsigned k = 0;
        int          cnt = -1;
        while (cnt < int'(i)) begin
            k++;
            if ((k & (k - 1)) != 0) cnt++;
        end
        return k;
    endfunction

    function automatic logic [7:0] tb_chk(input logic [63:0] d);
        logic [6:0]  acc = '0;
        int unsigned p;
        for (int i = 0; i < 64; i++) begin
            if (d[i]) begin
                p   = tb_pos(i);
                acc = acc ^ p[6:0];
            end
        end
        return {(^d) ^ (^acc), acc};
    endfunction

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ ({32'(i), 32'(i)} * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    // Memory model with fault injection port
    logic [63:0]   mem_d [DEPTH];
    logic [7:0]    mem_c [DEPTH];
    logic          flip_en = 1'b0;
    logic [AW-1:0] flip_addr = '0;
    logic [63:0]   flip_dm = '0;
    logic [7:0]    flip_cm = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] <= pat(i);
                mem_c[i] <= tb_chk(pat(i));
            end
        end else begin
            if (flip_en) begin
                mem_d[flip_addr] <= mem_d[flip_addr] ^ flip_dm;
                mem_c[flip_addr] <= mem_c[flip_addr] ^ flip_cm;
            end
            if (mem_wr_en) begin
                mem_d[mem_addr] <= mem_wdata;
                mem_c[mem_addr] <= mem_wchk;
            end
            if (mem_rd_en) begin
                mem_rdata <= mem_d[mem_addr];
                mem_rchk  <= mem_c[mem_addr];
            end
        end
    end

    typedef struct {
        bit            full;
        logic [AW-1:0] addr;
        bit            wr;
        logic [63:0]   wdata;
        logic [7:0]    wchk;
        bit            squash;
        bit            corr;
        bit            uncorr;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] golden [DEPTH];
    int          fault [DEPTH];   // 0 clean, 1 single, 2 double

    task automatic store(input int a, input int off, input st_size_e sz,
                         input logic [63:0] d, input string tag);
        exp_t        e;
        logic [63:0] m;
        int          nb, base;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nb   = 1 << int'(sz);
        base = off & ~(nb - 1);
        m    = golden[a];
        for (int b = 0; b < nb; b++) m[8*(base+b) +: 8] = d[8*b +: 8];
        e.full   = (sz == SZ_DWORD);
        e.addr   = AW'(a);
        e.wdata  = m;
        e.wchk   = tb_chk(m);
        e.tag    = tag;
        e.uncorr = !e.full && fault[a] == 2;
        e.corr   = !e.full && fault[a] == 1;
        e.squash = !e.full && fault[a] == 0 && (m == golden[a]);
        e.wr     = e.full || (!e.uncorr && (e.corr || m != golden[a]));
        if (e.wr) begin
            golden[a] = m;
            fault[a]  = 0;
        end
        sb.push_back(e);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_off   = 3'(off);
        req_size  = sz;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = '0;
    endtask

    task automatic corrupt(input int a, input logic [63:0] dm, input logic [7:0] cm, input int kind);
        wait (sb.size() == 0);
        @(negedge clk);
        flip_en   = 1'b1;
        flip_addr = AW'(a);
        flip_dm   = dm;
        flip_cm   = cm;
        @(negedge clk);
        flip_en  = 1'b0;
        fault[a] = kind;
    endtask

    // Monitor: samples just after the negative edge
    int          cyc = 0;
    bit          seen_rd = 0, seen_wr = 0, prev_rd = 0;
    int          rd_cyc = 0, wr_cyc = 0;
    logic [AW-1:0] rd_a = '0, wr_a = '0;
    logic [63:0] wr_d = '0;
    logic [7:0]  wr_c = '0;

    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            if (prev_rd) check(!req_ready && !mem_rd_en, "R8", "busy after read", {62'd0, req_ready, mem_rd_en}, 64'd0);
            if (mem_rd_en && mem_wr_en) check(1'b0, "R1", "read and write together", 64'd1, 64'd0);
            if (!st_done && (st_squash || st_corr || st_uncorr))
                check(1'b0, "R9", "flag without done", {61'd0, st_squash, st_corr, st_uncorr}, 64'd0);
            if (st_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check($countones({st_squash, st_corr, st_uncorr}) <= 1, "R9", "one flag at most",
                          {61'd0, st_squash, st_corr, st_uncorr}, 64'd0);
                    if (e.full) begin
                        check(!seen_rd, {e.tag, " R7"}, "read on full store", 64'(seen_rd), 64'd0);
                        check(seen_wr && wr_cyc == cyc - 1, {e.tag, " R7"}, "full write timing", 64'(cyc - wr_cyc), 64'd1);
                    end else begin
                        check(seen_rd && rd_cyc == cyc - 2, {e.tag, " R1"}, "read timing", 64'(cyc - rd_cyc), 64'd2);
                        check(rd_a == e.addr, {e.tag, " R1"}, "read address", 64'(rd_a), 64'(e.addr));
                    end
                    check(seen_wr == e.wr, e.tag, "write issued", 64'(seen_wr), 64'(e.wr));
                    if (e.wr && seen_wr) begin
                        check(wr_cyc == cyc - 1, {e.tag, " R1"}, "write timing", 64'(cyc - wr_cyc), 64'd1);
                        check(wr_a == e.addr, {e.tag, " R1"}, "write address", 64'(wr_a), 64'(e.addr));
                        check(wr_d == e.wdata, {e.tag, " R2"}, "merged data", wr_d, e.wdata);
                        check(wr_c == e.wchk, {e.tag, " R3"}, "check bits", 64'(wr_c), 64'(e.wchk));
                    end
                    check(st_squash == e.squash, {e.tag, " R4"}, "squash flag", 64'(st_squash), 64'(e.squash));
                    check(st_corr == e.corr, {e.tag, " R5"}, "corrected flag", 64'(st_corr), 64'(e.corr));
                    check(st_uncorr == e.uncorr, {e.tag, " R6"}, "uncorrectable flag", 64'(st_uncorr), 64'(e.uncorr));
                end
                seen_rd = 0;
                seen_wr = 0;
            end
            if (mem_rd_en) begin
                seen_rd = 1; rd_cyc = cyc; rd_a = mem_addr;
            end
            if (mem_wr_en) begin
                seen_wr = 1; wr_cyc = cyc; wr_a = mem_addr; wr_d = mem_wdata; wr_c = mem_wchk;
            end
            prev_rd = mem_rd_en;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        check(1'b0, "R1", "watchdog expired", 64'd1, 64'd0);
        report();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            golden[i] = pat(i);
            fault[i]  = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R8", "ready after reset", 64'(req_ready), 64'd1);
        check({st_done, st_squash, st_corr, st_uncorr, mem_wr_en, mem_rd_en} == '0, "R9",
              "status after reset", {58'd0, st_done, st_squash, st_corr, st_uncorr, mem_wr_en, mem_rd_en}, 64'd0);

        // R2/R3: byte change, then the same byte again (R4)
        store(3, 2, SZ_BYTE, {56'd0, ~golden[3][23:16]}, "R2 byte change");
        store(3, 2, SZ_BYTE, {56'd0, golden[3][23:16]}, "R4 byte silent");
        // R2: 16-bit at an odd offset aligns down to lane 2
        store(4, 3, SZ_HALF, {48'd0, ~golden[4][31:16]}, "R2 half aligned");
        store(4, 6, SZ_HALF, {48'd0, golden[4][63:48]}, "R4 half silent");
        store(5, 5, SZ_WORD, {32'd0, ~golden[5][63:32]}, "R2 word upper");
        store(5, 0, SZ_WORD, {32'd0, golden[5][31:0]}, "R4 word silent");
        for (int b = 0; b < 8; b++) store(6, b, SZ_BYTE, 64'(b * 8'h11 + 1), "R2 byte lane sweep");

        // R5: single data fault, silent store still scrubs, then squashes
        corrupt(7, 64'd1 << 40, 8'h00, 1);
        store(7, 1, SZ_BYTE, {56'd0, golden[7][15:8]}, "R5 data fault silent");
        store(7, 1, SZ_BYTE, {56'd0, golden[7][15:8]}, "R5 scrubbed then silent");
        corrupt(8, 64'd0, 8'h04, 1);
        store(8, 2, SZ_HALF, {48'd0, ~golden[8][47:32]}, "R5 check bit fault");
        corrupt(9, 64'd0, 8'h80, 1);
        store(9, 0, SZ_WORD, {32'd0, golden[9][31:0]}, "R5 parity bit fault");
        corrupt(12, 64'd1 << 5, 8'h00, 1);
        store(12, 0, SZ_BYTE, {56'd0, ~golden[12][7:0]}, "R5 fault in stored lane");

        // R6: double faults abort; R7 full stores repair and never squash
        corrupt(10, 64'h3, 8'h00, 2);
        store(10, 4, SZ_BYTE, {56'd0, ~golden[10][39:32]}, "R6 double data fault");
        store(10, 4, SZ_BYTE, {56'd0, golden[10][39:32]}, "R6 still bad");
        store(10, 0, SZ_DWORD, 64'hFEDC_BA98_7654_3210, "R7 full repair");
        store(10, 0, SZ_DWORD, 64'hFEDC_BA98_7654_3210, "R7 full same value");
        store(10, 7, SZ_BYTE, 64'h0000_0000_0000_00FE, "R4 silent after repair");
        corrupt(11, 64'd1 << 5, 8'h01, 2);
        store(11, 0, SZ_HALF, 16'h1234, "R6 data plus check fault");

        // R8: back-to-back mix
        store(13, 0, SZ_DWORD, 64'h1111_2222_3333_4444, "R7 b2b full");
        store(13, 1, SZ_BYTE, 64'h55, "R8 b2b byte");
        store(14, 2, SZ_HALF, 64'hABCD, "R8 b2b half");
        store(13, 1, SZ_BYTE, 64'h55, "R4 b2b silent");
        store(15, 4, SZ_WORD, 64'hDEAD_BEEF, "R8 b2b word");

        wait (sb.size() == 0);
        repeat (4) @(negedge clk);
        report();
    end

endmodule